// File: doc/BRIEF.md
# Dynamic Data Bus Sizing Sequencer

This block connects a 32-bit transfer request to an external bus whose width is chosen per bus cycle by the responding device. A request carries a dword address, four active-low byte enables, write data and a direction. The sequencer then drives one or two external bus cycles. On each cycle it samples an active-low narrow-port input on the same clock edge where the active-low ready input is seen low. A 32-bit device takes the whole word in one cycle. A 16-bit device moves everything over data bits 15:0, so the block splits the transfer when the enabled bytes lie in both halves, and steers the upper lanes down when only the upper half is enabled.

Read data from each sub-cycle is merged into one 32-bit result. A single-cycle `done` pulse marks the end of the request, and that result is presented with it. New requests are taken only while the sequencer is idle.

The states are `ST_IDLE`, `ST_WHOLE` (first bus cycle, original enables) and `ST_UPPER` (follow-up cycle for bytes 2 and 3). The transitions are:
- start: `ST_IDLE` to `ST_WHOLE`, on an accepted request with at least one enable active.
- skip: `ST_IDLE` to `ST_IDLE` with `done`, on an accepted request with no enable active.
- finish: `ST_WHOLE` to `ST_IDLE`, on ready when no split is needed.
- split: `ST_WHOLE` to `ST_UPPER`, on ready with the narrow input active and enables in both halves.
- last: `ST_UPPER` to `ST_IDLE`, on ready.

Top module: `bus_size_seq`

## Requirements
- R1: After reset `req_ready` is 1, `bus_cyc` is 0 and `done` is 0.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 for as long as `bus_cyc` is 1. A request raised while the sequencer is busy is ignored: it starts no bus cycle and writes nothing.
- R3: An accepted request with `req_be_n` = 4'b1111 raises `done` in the next cycle and starts no bus cycle.
- R4: Bit i of `req_be_n` enables byte i, and byte i travels on data bits 8i+7:8i. If the device answers wide, or if only enables 0 and/or 1 are active, the transfer takes one bus cycle. That cycle drives the request's enables and write data unchanged. A read takes the whole `bus_rdata` word.
- R5: When only enables 2 and/or 3 are active, bits 15:0 of `bus_wdata` repeat bits 31:16. If the device answers narrow, the transfer ends after one cycle, and read bits 15:0 become result bytes 2 and 3.
- R6: When at least one of enables 0/1 and at least one of enables 2/3 are active, and the device answers narrow, a second cycle follows. The first cycle takes read bits 15:0 as bytes 0 and 1. The second cycle drives enables {original 3:2, 2'b11}, with write bytes 2 and 3 on bits 7:0 and 15:8 (and on 31:16).
- R7: While `bus_rdy_n` is 1 the bus cycle is held: `bus_addr`, `bus_be_n` and `bus_wdata` stay unchanged.
- R8: The narrow input is sampled again on the second cycle. If that cycle ends wide, result bytes 2 and 3 come from read bits 31:16.
- R9: `done` is 1 for one cycle in the cycle after the last sub-cycle's ready edge. `rdata` then holds the merged read, with every byte whose enable was inactive at 0. For writes `rdata` is all 0.
- R10: `bus_addr` equals the accepted request address on every bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | ADDR_W | Dword address of the request |
| req_be_n | input | 4 | Active-low byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data in natural lanes |
| done | output | 1 | Request finished (one cycle) |
| rdata | output | 32 | Merged read data, valid with done |
| bus_cyc | output | 1 | External bus cycle in progress |
| bus_addr | output | ADDR_W | External dword address |
| bus_be_n | output | 4 | External active-low byte enables |
| bus_write | output | 1 | External direction |
| bus_wdata | output | 32 | External write data, lanes steered |
| bus_rdata | input | 32 | External read data |
| bus_rdy_n | input | 1 | Active-low cycle completion |
| bus_narrow_n | input | 1 | Active-low 16-bit port indication, sampled with ready |

## Verification
The checker watches every cycle for the following: no request is accepted during a bus cycle; a zero-enable request completes at once; duplicated upper lanes appear whenever the lower half is unused; the enable pattern is correct on a follow-up cycle; the bus is held during wait states; and `done` follows each completing edge. Whether the bytes land in the right places in memory and in `rdata` can only be shown by the bench. The bench sweeps every enable pattern in both directions, for every wide/narrow pairing of the first and second cycles and for zero and one wait states, and compares the results with a modelled 32-bit or 16-bit device.

// File: rtl/bss_pkg.sv
package bss_pkg;
    localparam int LANES  = 4;
    localparam int DATA_W = 8 * LANES;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WHOLE = 2'd1,
        ST_UPPER = 2'd2
    } seq_state_t;

    function automatic logic lo_used(input logic [LANES-1:0] be_n);
        return ~&be_n[LANES/2-1:0];
    endfunction

    function automatic logic hi_used(input logic [LANES-1:0] be_n);
        return ~&be_n[LANES-1:LANES/2];
    endfunction
endpackage

// File: rtl/bss_fsm.sv
module bss_fsm
    import bss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       empty_req,
    input  logic       both_halves,
    input  logic       hi_only,
    input  logic       rdy_n,
    input  logic       narrow_n,
    output seq_state_t state,
    output logic       cap_full,
    output logic       cap_lo,
    output logic       cap_hi_low,
    output logic       cap_hi_up,
    output logic       done
);
    seq_state_t nxt;
    logic       finish;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= finish;
        end
    end

    always_comb begin
        nxt        = state;
        finish     = 1'b0;
        cap_full   = 1'b0;
        cap_lo     = 1'b0;
        cap_hi_low = 1'b0;
        cap_hi_up  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (empty_req) finish = 1'b1;
                    else           nxt    = ST_WHOLE;
                end
            end
            ST_WHOLE: begin
                if (!rdy_n) begin
                    if (!narrow_n && both_halves) begin
                        cap_lo = 1'b1;
                        nxt    = ST_UPPER;
                    end else begin
                        finish = 1'b1;
                        nxt    = ST_IDLE;
                        if (!narrow_n && hi_only) cap_hi_low = 1'b1;
                        else                      cap_full   = 1'b1;
                    end
                end
            end
            ST_UPPER: begin
                if (!rdy_n) begin
                    finish = 1'b1;
                    nxt    = ST_IDLE;
                    if (!narrow_n) cap_hi_low = 1'b1;
                    else           cap_hi_up  = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bss_wr_steer.sv
module bss_wr_steer
    import bss_pkg::*;
(
    input  seq_state_t          state,
    input  logic [LANES-1:0]    be_n,
    input  logic [DATA_W-1:0]   wdata,
    output logic [LANES-1:0]    bus_be_n,
    output logic [DATA_W-1:0]   bus_wdata
);
    logic [HALF_W-1:0] up;
    assign up = wdata[DATA_W-1:HALF_W];

    always_comb begin
        bus_be_n  = '1;
        bus_wdata = '0;
        unique case (state)
            ST_WHOLE: begin
                bus_be_n  = be_n;
                bus_wdata = lo_used(be_n) ? wdata : {up, up};
            end
            ST_UPPER: begin
                bus_be_n  = {be_n[LANES-1:LANES/2], {(LANES/2){1'b1}}};
                bus_wdata = {up, up};
            end
            default: begin
                bus_be_n  = '1;
                bus_wdata = '0;
            end
        endcase
    end
endmodule

// File: rtl/bss_rd_merge.sv
module bss_rd_merge
    import bss_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                cap_full,
    input  logic                cap_lo,
    input  logic                cap_hi_low,
    input  logic                cap_hi_up,
    input  logic [DATA_W-1:0]   bus_rdata,
    input  logic [LANES-1:0]    be_n,
    input  logic                is_write,
    output logic [DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else begin
            if (cap_full)   acc <= bus_rdata;
            if (cap_lo)     acc[HALF_W-1:0] <= bus_rdata[HALF_W-1:0];
            if (cap_hi_low) acc[DATA_W-1:HALF_W] <= bus_rdata[HALF_W-1:0];
            if (cap_hi_up)  acc[DATA_W-1:HALF_W] <= bus_rdata[DATA_W-1:HALF_W];
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_mask
        assign rdata[8*i +: 8] = (is_write || be_n[i]) ? 8'h00 : acc[8*i +: 8];
    end
endmodule

// File: rtl/bus_size_seq.sv
module bus_size_seq
    import bss_pkg::*;
#(
    parameter int ADDR_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be_n,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              done,
    output logic [31:0]       rdata,
    output logic              bus_cyc,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [3:0]        bus_be_n,
    output logic              bus_write,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_rdy_n,
    input  logic              bus_narrow_n
);
    seq_state_t        state;
    logic              start;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic              wr_q;
    logic [DATA_W-1:0] wd_q;
    logic              cap_full, cap_lo, cap_hi_low, cap_hi_up;

    assign req_ready = (state == ST_IDLE);
    assign start     = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            be_q   <= '1;
            wr_q   <= 1'b0;
            wd_q   <= '0;
        end else if (start) begin
            addr_q <= req_addr;
            be_q   <= req_be_n;
            wr_q   <= req_write;
            wd_q   <= req_wdata;
        end
    end

    bss_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .empty_req  (&req_be_n),
        .both_halves(lo_used(be_q) && hi_used(be_q)),
        .hi_only    (!lo_used(be_q)),
        .rdy_n      (bus_rdy_n),
        .narrow_n   (bus_narrow_n),
        .state      (state),
        .cap_full   (cap_full),
        .cap_lo     (cap_lo),
        .cap_hi_low (cap_hi_low),
        .cap_hi_up  (cap_hi_up),
        .done       (done)
    );

    bss_wr_steer u_steer (
        .state    (state),
        .be_n     (be_q),
        .wdata    (wd_q),
        .bus_be_n (bus_be_n),
        .bus_wdata(bus_wdata)
    );

    bss_rd_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .cap_full  (cap_full),
        .cap_lo    (cap_lo),
        .cap_hi_low(cap_hi_low),
        .cap_hi_up (cap_hi_up),
        .bus_rdata (bus_rdata),
        .be_n      (be_q),
        .is_write  (wr_q),
        .rdata     (rdata)
    );

    assign bus_cyc   = (state != ST_IDLE);
    assign bus_addr  = addr_q;
    assign bus_write = wr_q;
endmodule

// File: rtl/bss_checker.sv
module bss_checker #(
    parameter int ADDR_W = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [3:0]        req_be_n,
    input logic              done,
    input logic              bus_cyc,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be_n,
    input logic [31:0]       bus_wdata,
    input logic              bus_rdy_n,
    input logic              bus_narrow_n
);
    logic lo_on, hi_on;
    assign lo_on = ~&bus_be_n[1:0];
    assign hi_on = ~&bus_be_n[3:2];

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> !req_ready);

    a_r3_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_be_n == 4'hF) |=> (done && !bus_cyc));

    a_r5_upper_dup: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !lo_on) |-> (bus_wdata[15:0] == bus_wdata[31:16]));

    a_r6_follow_be: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_rdy_n && !bus_narrow_n && lo_on && hi_on)
        |=> (bus_cyc && bus_be_n[1:0] == 2'b11 && bus_be_n[3:2] == $past(bus_be_n[3:2])));

    a_r7_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_rdy_n)
        |=> (bus_cyc && $stable(bus_be_n) && $stable(bus_addr) && $stable(bus_wdata)));

    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_rdy_n && !(!bus_narrow_n && lo_on && hi_on)) |=> (done && !bus_cyc));
endmodule

bind bus_size_seq bss_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_be_n    (req_be_n),
    .done        (done),
    .bus_cyc     (bus_cyc),
    .bus_addr    (bus_addr),
    .bus_be_n    (bus_be_n),
    .bus_wdata   (bus_wdata),
    .bus_rdy_n   (bus_rdy_n),
    .bus_narrow_n(bus_narrow_n)
);

// File: tb/bus_size_seq_bench.sv
module bus_size_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_be_n = 4'hF;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          done;
    logic [31:0]   rdata;
    logic          bus_cyc;
    logic [AW-1:0] bus_addr;
    logic [3:0]    bus_be_n;
    logic          bus_write;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata = '0;
    logic          bus_rdy_n = 1'b1;
    logic          bus_narrow_n = 1'b1;

    int total = 0;
    int bad = 0;

    // device model state
    logic [31:0]   mem;
    int            waits = 0;
    logic          nar0 = 1'b0, nar1 = 1'b0;
    int            ncyc = 0;
    int            wcnt = 0;
    logic [3:0]    be_log [2];
    logic [AW-1:0] exp_addr = '0;
    int            addr_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_size_seq #(.ADDR_W(AW)) u_bus_size_seq (.*);

    always @(negedge clk) begin
        if (!bus_cyc) begin
            bus_rdy_n = 1'b1;
            wcnt = 0;
        end else begin
            if (!bus_rdy_n) wcnt = 0;
            if (wcnt == waits) begin
                logic nar;
                int   half;
                nar = (ncyc == 0) ? nar0 : nar1;
                bus_rdy_n = 1'b0;
                bus_narrow_n = !nar;
                if (bus_addr != exp_addr) addr_bad++;
                if (ncyc < 2) be_log[ncyc] = bus_be_n;
                if (nar) begin
                    half = (~&bus_be_n[1:0]) ? 0 : 1;
                    bus_rdata = {16'hDEAD, mem[16*half +: 16]};
                    if (bus_write)
                        for (int k = 0; k < 2; k++)
                            if (!bus_be_n[2*half+k]) mem[8*(2*half+k) +: 8] = bus_wdata[8*k +: 8];
                end else begin
                    bus_rdata = mem;
                    if (bus_write)
                        for (int i = 0; i < 4; i++)
                            if (!bus_be_n[i]) mem[8*i +: 8] = bus_wdata[8*i +: 8];
                end
                ncyc++;
            end else begin
                bus_rdy_n = 1'b1;
                wcnt++;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wait_done(output logic seen);
        seen = 1'b0;
        for (int t = 0; t < 40 && !seen; t++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic run_one(input logic [3:0] be, input logic wr, input logic n0,
                           input logic n1, input int ws, input logic [AW-1:0] a);
        logic [31:0] init, wd, exp_mem, exp_rd;
        logic        seen, lo, hi;
        int          exp_cyc;
        init = 32'hA1B2C3D4 ^ {be, 4'h0, 24'h0} ^ {28'h0, be};
        wd   = 32'h5E6F7081 + {28'h0, be};
        mem = init; nar0 = n0; nar1 = n1; waits = ws; ncyc = 0; addr_bad = 0;
        exp_addr = a; be_log[0] = 4'hF; be_log[1] = 4'hF;
        lo = ~&be[1:0]; hi = ~&be[3:2];
        exp_cyc = (be == 4'hF) ? 0 : ((n0 && lo && hi) ? 2 : 1);
        exp_mem = init; exp_rd = 32'h0;
        for (int i = 0; i < 4; i++) if (!be[i]) begin
            if (wr) exp_mem[8*i +: 8] = wd[8*i +: 8];
            else    exp_rd[8*i +: 8]  = init[8*i +: 8];
        end
        req_valid = 1'b1; req_be_n = be; req_write = wr; req_wdata = wd; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(seen);
        chk(seen, "R9 done seen", {31'h0, seen}, 32'h1);
        chk(rdata == exp_rd, "R9 R4 R5 R6 R8 rdata", rdata, exp_rd);
        chk(mem == exp_mem, "R4 R5 R6 R8 written bytes", mem, exp_mem);
        chk(ncyc == exp_cyc, "R3 R4 R6 bus cycle count", ncyc, exp_cyc);
        if (exp_cyc >= 1) chk(be_log[0] == be, "R4 first cycle enables", {28'h0, be_log[0]}, {28'h0, be});
        if (exp_cyc == 2) chk(be_log[1] == {be[3:2], 2'b11}, "R6 follow-up enables",
                              {28'h0, be_log[1]}, {28'h0, be[3:2], 2'b11});
        chk(addr_bad == 0, "R10 bus address", addr_bad, 0);
        @(negedge clk);
        chk(!done, "R9 done one cycle", {31'h0, done}, 32'h0);
    endtask

    initial begin
        logic seen;
        logic [31:0] keep;
        repeat (2) @(negedge clk);
        chk(req_ready && !bus_cyc && !done, "R1 reset state",
            {29'h0, req_ready, bus_cyc, done}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_cyc && !done, "R1 after release",
            {29'h0, req_ready, bus_cyc, done}, 32'h4);

        for (int be = 0; be < 16; be++)
            for (int wr = 0; wr < 2; wr++)
                for (int nm = 0; nm < 4; nm++)
                    for (int ws = 0; ws < 2; ws++)
                        run_one(be[3:0], wr[0], nm[0], nm[1], ws, AW'(30'h1234_567 + be));

        // R2: request raised during a bus cycle is ignored
        mem = 32'h11223344; nar0 = 1'b0; nar1 = 1'b0; waits = 3; ncyc = 0;
        exp_addr = 30'h0ABC;
        req_valid = 1'b1; req_be_n = 4'h0; req_write = 1'b0; req_addr = 30'h0ABC;
        @(negedge clk);
        chk(!req_ready, "R2 busy not ready", {31'h0, req_ready}, 32'h0);
        req_write = 1'b1; req_wdata = 32'hFFFF_FFFF; req_addr = 30'h0DEF;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(seen);
        keep = rdata;
        chk(keep == 32'h11223344, "R2 first request result", keep, 32'h11223344);
        repeat (5) @(negedge clk);
        chk(ncyc == 1, "R2 no extra bus cycle", ncyc, 1);
        chk(mem == 32'h11223344, "R2 busy write ignored", mem, 32'h11223344);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule